// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the chip last came out of reset. Four reset sources each deliver a one-cycle pulse: power-on, low-voltage, clock-monitor failure and the external reset pin. Each pulse sets a sticky flag. The flags stay set until software clears them by writing 1s. The flags are mutually qualified, so a power-related cause hides the lesser causes. The value software reads is always one that the exclusion rule allows.

The block also stores a 2-bit clock-out divider code. It takes this code from two strap pins on every power-on, low-voltage or clock-monitor reset. It also holds a protocol-clock source select bit and a clock-monitor enable bit, and drives both on output ports to the clocking logic. The clock monitor, the divider and the clock multiplexer live outside this block. Software reaches the registers through a plain address/write-enable port with 16-bit data. Reads are combinational from the address.

Top module: `rst_cause_reg`

## Requirements
- R1: A pulse on `por_pulse_i` or `lvr_pulse_i` sets the matching flag on the next clock edge. The flags sit in the status word at bit 2 (power-on) and bit 0 (low-voltage).
- R2: A write to the status address (0) with 1 in a flag bit (bit 0 low-voltage, bit 1 clock-monitor, bit 2 power-on, bit 3 external) clears that flag. A 0 in a flag bit leaves that flag unchanged.
- R3: While the power-on or low-voltage flag is 1, the clock-monitor flag (bit 1) and the external flag (bit 3) are 0. A power-on or low-voltage pulse clears both in the same edge. While a power flag is held, clock-monitor and external pulses set nothing.
- R4: A power-on, low-voltage or clock-monitor pulse loads `strap_i` into the divider code at status bits 10..9.
- R5: If a reset pulse and a status write arrive in the same cycle, the pulse wins. The flag is set and the divider code comes from the straps, not from the write data.
- R6: An external reset pulse sets flag bit 3 when no power flag is set. It leaves the divider code unchanged. An external pulse alone does not clear a power flag.
- R7: A status write loads bit 8 into the clock-source select, which drives `clk_src_sel_o`. 0 selects the crystal clock and 1 selects the alternate protocol clock. Bits 10..9 of the write load the divider code when no capturing pulse is present.
- R8: After `rst_ni` every flag, the divider code, the clock-source select and the monitor enable are 0. The monitor enable is bit 0 at the enable address (1). Only a write there changes it, and it drives `mon_en_o`.
- R9: Status bits 15..11 and 7..4 read as 0 whatever was written. Reads of the enable address return 0 above bit 0.
- R10: A low-voltage pulse clears a set power-on flag. A write to an unmapped address changes no state, and reading an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_pulse_i | input | 1 | Power-on reset event, one cycle |
| lvr_pulse_i | input | 1 | Low-voltage reset event, one cycle |
| cmr_pulse_i | input | 1 | Clock-monitor reset event, one cycle |
| ext_pulse_i | input | 1 | External pin reset event, one cycle |
| strap_i | input | 2 | Divider code strap pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address (0 status, 1 enable) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| clk_src_sel_o | output | 1 | Protocol clock source select |
| mon_en_o | output | 1 | Clock monitor enable |

## Verification
The hardest states to reach are collisions. One is a reset pulse in the same cycle as a write-1-to-clear or a divider-code write to the status register. Another is a clock-monitor or external pulse that arrives while a power flag is still held. The stimulus builds each case in steps. It first records a power cause, then fires the lesser pulses against it. It then drives a low-voltage pulse together with a status write that tries to clear the flag and load another code. A reference model updated per cycle predicts each read.

// File: rtl/rst_cause_pkg.sv
`timescale 1ns/1ps
package rst_cause_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FLG_LV    = 0;
  localparam int FLG_CM    = 1;
  localparam int FLG_POR   = 2;
  localparam int FLG_EXT   = 3;
  localparam int CODE_W    = 2;
  localparam int CODE_LSB  = 9;
  localparam int ECS_BIT   = 8;
  localparam int MEN_BIT   = 0;
  // flags that dominate, flags they suppress
  localparam logic [NUM_FLAGS-1:0] PWR_MASK  = (1 << FLG_LV) | (1 << FLG_POR);
  localparam logic [NUM_FLAGS-1:0] KILL_MASK = (1 << FLG_CM) | (1 << FLG_EXT);
endpackage

// File: rtl/rst_flag_bank.sv
`timescale 1ns/1ps
module rst_flag_bank #(
  parameter int            NF        = 4,
  parameter logic [NF-1:0] PWR_MASK  = '0,
  parameter logic [NF-1:0] KILL_MASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] init_i,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] flag_q, raw, nxt;
  logic          pwr_any;

  always_comb begin
    raw     = set_i | (flag_q & ~clr_i & ~init_i);
    pwr_any = |(raw & PWR_MASK);
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    if (KILL_MASK[i]) begin : g_kill
      assign nxt[i] = pwr_any ? 1'b0 : raw[i];
      AST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(flag_o & PWR_MASK)) |-> !flag_o[i]); // R3
    end else begin : g_keep
      assign nxt[i] = raw[i];
    end
    if (PWR_MASK[i]) begin : g_pwr
      AST_PWR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> flag_o[i]); // R1
    end
    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]); // R2
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= nxt;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] strap_i,
  input  logic         wr_i,
  input  logic [W-1:0] wcode_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (cap_i) code_q <= strap_i;  // capture beats write
    else if (wr_i)  code_q <= wcode_i;
  end

  assign code_o = code_q;

  AST_STRAP_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (code_o == $past(strap_i))); // R4
  AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !wr_i) |=> $stable(code_o)); // R6
endmodule

// File: rtl/cfg_bit.sv
`timescale 1ns/1ps
module cfg_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= 1'b0;
    else if (wr_i) q <= wbit_i;
  end

  assign q_o = q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o)); // R8
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o == $past(wbit_i))); // R7
endmodule

// File: rtl/rst_cause_reg.sv
`timescale 1ns/1ps
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int ENA_ADDR  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_pulse_i,
  input  logic              lvr_pulse_i,
  input  logic              cmr_pulse_i,
  input  logic              ext_pulse_i,
  input  logic [CODE_W-1:0] strap_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_src_sel_o,
  output logic              mon_en_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(ENA_ADDR);

  logic                 wr_stat, wr_ena, pwr_evt, cap;
  logic [NUM_FLAGS-1:0] set_v, clr_v, init_v, flags;
  logic [CODE_W-1:0]    code;
  logic [DATA_W-1:0]    stat_word, ena_word;

  assign wr_stat = wr_en_i && (addr_i == STAT_A);
  assign wr_ena  = wr_en_i && (addr_i == ENA_A);
  assign pwr_evt = por_pulse_i | lvr_pulse_i;
  assign cap     = pwr_evt | cmr_pulse_i;

  always_comb begin
    set_v          = '0;
    set_v[FLG_LV]  = lvr_pulse_i;
    set_v[FLG_CM]  = cmr_pulse_i;
    set_v[FLG_POR] = por_pulse_i;
    set_v[FLG_EXT] = ext_pulse_i;
    clr_v          = wr_stat ? wdata_i[NUM_FLAGS-1:0] : '0;
    // power events wipe monitor/power-on history before recording
    init_v          = '0;
    init_v[FLG_POR] = lvr_pulse_i;
    init_v[FLG_CM]  = pwr_evt;
    init_v[FLG_EXT] = pwr_evt;
  end

  rst_flag_bank #(
    .NF       (NUM_FLAGS),
    .PWR_MASK (PWR_MASK),
    .KILL_MASK(KILL_MASK)
  ) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .init_i(init_v),
    .flag_o(flags)
  );

  strap_capture #(.W(CODE_W)) u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .strap_i(strap_i),
    .wr_i   (wr_stat),
    .wcode_i(wdata_i[CODE_LSB +: CODE_W]),
    .code_o (code)
  );

  cfg_bit u_ecs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_stat),
    .wbit_i(wdata_i[ECS_BIT]),
    .q_o   (clk_src_sel_o)
  );

  cfg_bit u_men (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_ena),
    .wbit_i(wdata_i[MEN_BIT]),
    .q_o   (mon_en_o)
  );

  always_comb begin
    stat_word                       = '0;
    stat_word[NUM_FLAGS-1:0]        = flags;
    stat_word[ECS_BIT]              = clk_src_sel_o;
    stat_word[CODE_LSB +: CODE_W]   = code;
    ena_word                        = '0;
    ena_word[MEN_BIT]               = mon_en_o;
    if (addr_i == STAT_A)     rdata_o = stat_word;
    else if (addr_i == ENA_A) rdata_o = ena_word;
    else                      rdata_o = '0;
  end

  AST_PWR_CLEARS_LESSER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_evt |=> (!flags[FLG_CM] && !flags[FLG_EXT])); // R3
  AST_EXT_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_pulse_i && !cap && !wr_stat) |=> $stable(code)); // R6
  AST_LVR_CLR_POR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvr_pulse_i && !por_pulse_i) |=> !flags[FLG_POR]); // R10
endmodule

// File: tb/rst_cause_reg_tb.sv
`timescale 1ns/1ps
module rst_cause_reg_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] exp_rd;
    logic        exp_ecs;
    logic        exp_men;
    logic [3:0]  addr;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por = 0, lvr = 0, cmr = 0, ext = 0;
  logic [1:0]  strap = 0;
  logic        we = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        ecs_o, men_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  sb_item_t sb_q[$];
  event item_ev;

  // reference state
  logic [3:0] m_f = 0;   // {ext,por,cm,lv}
  logic [1:0] m_code = 0;
  logic       m_ecs = 0, m_men = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .por_pulse_i(por), .lvr_pulse_i(lvr), .cmr_pulse_i(cmr), .ext_pulse_i(ext),
    .strap_i(strap), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .clk_src_sel_o(ecs_o), .mon_en_o(men_o)
  );

  function automatic logic [15:0] exp_word(input logic [3:0] a);
    if (a == 4'd0) return {5'b0, m_code, m_ecs, 4'b0, m_f};
    if (a == 4'd1) return {15'b0, m_men};
    return 16'h0;
  endfunction

  // p = {ext,por,cm,lv}
  task automatic cyc(input logic [3:0] p, input logic [1:0] s,
                     input logic w, input logic [3:0] a, input logic [15:0] d);
    logic [3:0] clr;
    logic lv_n, por_n, cm_n, ext_n, pw;
    @(negedge clk);
    {ext, por, cmr, lvr} = p;
    strap = s; we = w; addr = a; wdata = d;
    clr   = (w && a == 4'd0) ? d[3:0] : 4'b0;
    lv_n  = p[0] | (m_f[0] & ~clr[0]);
    por_n = p[2] | (m_f[2] & ~clr[2] & ~p[0]);
    pw    = lv_n | por_n;
    cm_n  = !pw && (p[1] | (m_f[1] & ~clr[1] & ~(p[0] | p[2])));
    ext_n = !pw && (p[3] | (m_f[3] & ~clr[3] & ~(p[0] | p[2])));
    if (p[0] | p[1] | p[2]) m_code = s;
    else if (w && a == 4'd0) m_code = d[10:9];
    if (w && a == 4'd0) m_ecs = d[8];
    if (w && a == 4'd1) m_men = d[0];
    m_f = {ext_n, por_n, cm_n, lv_n};
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    sb_item_t it;
    @(negedge clk);
    {ext, por, cmr, lvr} = 4'b0;
    we = 0; addr = a; wdata = 16'h0;
    #1;
    it.exp_rd = exp_word(a); it.exp_ecs = m_ecs; it.exp_men = m_men;
    it.addr = a; it.tag = tag;
    sb_q.push_back(it);
    ->item_ev;
  endtask

  initial begin : monitor
    sb_item_t it;
    forever begin
      @(item_ev);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (rdata !== it.exp_rd || ecs_o !== it.exp_ecs || men_o !== it.exp_men) begin
          n_fail++;
          $display("FAIL %s addr=%0d: rdata=%h ecs=%b men=%b expected rdata=%h ecs=%b men=%b",
                   it.tag, it.addr, rdata, ecs_o, men_o, it.exp_rd, it.exp_ecs, it.exp_men);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd(0, "R8 reset status");
    rd(1, "R8 reset enable");
    cyc(4'b1000, 2'b11, 0, 0, 0);        rd(0, "R6 ext sets flag, no strap capture");
    cyc(4'b0000, 2'b11, 1, 0, 16'h0400); rd(0, "R2 write 0 keeps flag, R7 code write");
    cyc(4'b1000, 2'b01, 0, 0, 0);        rd(0, "R6 ext again keeps code");
    cyc(4'b0010, 2'b01, 0, 0, 0);        rd(0, "R4 cm pulse captures strap");
    cyc(4'b0000, 2'b00, 1, 0, 16'h0202); rd(0, "R2 w1c clock-monitor flag");
    cyc(4'b0100, 2'b11, 0, 0, 0);        rd(0, "R3 por clears lesser flags");
    cyc(4'b0010, 2'b01, 0, 0, 0);        rd(0, "R3 cm suppressed under por, R4 capture");
    cyc(4'b1000, 2'b10, 0, 0, 0);        rd(0, "R3 ext suppressed under por");
    cyc(4'b0001, 2'b10, 1, 0, 16'h0705); rd(0, "R5 set beats clear, R10 lvr clears por");
    rd(0, "R7 ecs bit read back");
    cyc(4'b0000, 2'b00, 1, 0, 16'h0001); rd(0, "R2 w1c lv flag");
    cyc(4'b0000, 2'b00, 1, 1, 16'hFFFF); rd(1, "R8 enable write");
    rd(0, "R9 enable write leaves status");
    cyc(4'b0000, 2'b00, 1, 0, 16'hF9F0); rd(0, "R9 reserved bits read 0");
    cyc(4'b0000, 2'b00, 1, 7, 16'hFFFF); rd(0, "R10 unmapped write ignored");
    rd(7, "R10 unmapped read 0");
    rd(1, "R10 enable unchanged by unmapped write");
    cyc(4'b0000, 2'b00, 1, 1, 16'h0000); rd(1, "R8 enable cleared");
    cyc(4'b0101, 2'b01, 0, 0, 0);        rd(0, "R1 por and lvr together");
    cyc(4'b0000, 2'b00, 1, 0, 16'h0004); rd(0, "R2 clear only por");
    cyc(4'b1000, 2'b10, 0, 0, 0);        rd(0, "R3 ext suppressed under lv");
    cyc(4'b0000, 2'b00, 1, 0, 16'h0001); cyc(4'b1000, 2'b10, 0, 0, 0);
    rd(0, "R6 ext after power flags cleared");
    cyc(4'b0100, 2'b00, 0, 0, 0);        rd(0, "R1 por flag set");
    cyc(4'b1000, 2'b00, 0, 0, 0);        rd(0, "R6 ext leaves por flag");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule